// File: doc/BRIEF.md
# Sequenced Channel Read Port

This block gives each of several receive channels a single host read address. Each read from that address returns the next item from a short list of data types that software has set up for that channel. A channel offers six data types: the in-phase sample, the quadrature sample, the gain-control value in real-time form, the gain-control value in sampled form, and two range-control values. When the channel signals that a new output is ready, the block captures all six values at once and rewinds the list pointer. A burst of host reads then walks through one consistent sample set in the programmed order.

Each channel has a 32-bit program word. It holds up to eight 3-bit slot codes, the index of the last slot in use, and an interrupt enable. When the enable is set, a new output raises that channel's interrupt line. The line stays high until the host makes the first read of the new sequence. Read data is registered: it appears on `rd_data` in the cycle after the read strobe. Generating the sample values is left to the channel logic that feeds this block.

Top module: `seqrd_port`

## Requirements
- R1: While reset is low, and in the first cycle after it, `rd_data` is 0, every `irq` bit is 0, and every channel's list pointer is at slot 0.
- R2: Slot k of a program word sits in bits [3k+2:3k]. Code 0 selects I, 1 selects Q, 2 the real-time gain, 3 the sampled gain, 4 range value A and 5 range value B. Codes 6 and 7 return zero.
- R3: A read hits channel c when `host_rd` is high at a clock edge and `host_addr` equals BASE_ADDR+c (4 to 7 by default). `rd_data` then shows that channel's data at its current slot from the next cycle on. The read leaves the pointers of the other channels unchanged.
- R4: Each read that hits a channel, with no new output on that channel in the same cycle, moves its pointer to the next slot.
- R5: Bits [26:24] of the program word give the index of the last slot in use. A read at that slot returns the pointer to slot 0.
- R6: A `new_out` pulse on a channel captures all six of its input values and sets its pointer to slot 0.
- R7: Reads return the captured values. Changes on the value inputs without a `new_out` pulse are not seen.
- R8: If bit 31 of the program word is 1, a `new_out` pulse sets that channel's `irq` in the next cycle. If bit 31 is 0, the `irq` stays 0.
- R9: An `irq` that is set clears after the first read of the new sequence, that is, a read taken while the pointer is at slot 0.
- R10: A read strobe with an address outside the channel window leaves `rd_data` and all pointers unchanged.
- R11: If a read and a `new_out` reach the same channel in the same cycle, the read returns the previously captured value at the old pointer. The pointer still goes to slot 0, and the interrupt is set as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_addr | input | AW (3) | Host direct address |
| new_out | input | NCH (4) | New-output strobe, one bit per channel |
| i_val | input | NCH*DW | In-phase value per channel |
| q_val | input | NCH*DW | Quadrature value per channel |
| agc_rt | input | NCH*DW | Real-time gain value per channel |
| agc_smp | input | NCH*DW | Sampled gain value per channel |
| rng_a | input | NCH*DW | First range-control value per channel |
| rng_b | input | NCH*DW | Second range-control value per channel |
| seq_prog | input | NCH*32 | Program word per channel: slots, last index, interrupt enable |
| rd_data | output | DW (16) | Registered read data |
| irq | output | NCH (4) | Per-channel new-output interrupt |

## Verification
A read strobe driven in cycle n loads `rd_data` at the edge that ends cycle n. The same edge moves the pointer and clears a pending interrupt. A `new_out` pulse in cycle n shows on `irq`, and on the captured values, from the edge that ends cycle n. Inputs change only on falling edges. The scoreboard monitor wakes on the rising edge where a hit read is active and compares one time unit later, once the register has settled. The interrupt, reset and out-of-window checks sample on the falling edge that follows the edge under test.

// File: rtl/seqrd_pkg.sv
package seqrd_pkg;
  localparam int SLOT_W     = 3;
  localparam int SEQ_MAX    = 8;
  localparam int PROG_W     = 32;
  localparam int LAST_LSB   = 24;
  localparam int IRQ_EN_BIT = 31;
  localparam int NTYPES     = 6;

  typedef enum logic [SLOT_W-1:0] {
    DT_I      = 3'd0,
    DT_Q      = 3'd1,
    DT_AGC_RT = 3'd2,
    DT_AGC_SM = 3'd3,
    DT_RNG_A  = 3'd4,
    DT_RNG_B  = 3'd5,
    DT_NONE6  = 3'd6,
    DT_NONE7  = 3'd7
  } dtype_e;

  // slot code at a given index of the packed slot field
  function automatic logic [SLOT_W-1:0] slot_code(
    input logic [SEQ_MAX*SLOT_W-1:0] slots,
    input logic [SLOT_W-1:0] idx);
    return slots[int'(idx)*SLOT_W +: SLOT_W];
  endfunction

  // pointer after one read: wraps past the last slot in use
  function automatic logic [SLOT_W-1:0] step_ptr(
    input logic [SLOT_W-1:0] ptr,
    input logic [SLOT_W-1:0] last);
    return (ptr >= last) ? '0 : ptr + 1'b1;
  endfunction
endpackage

// File: rtl/seqrd_sel.sv
module seqrd_sel
  import seqrd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [SLOT_W-1:0]    code,
  input  logic [NTYPES*DW-1:0] vals,
  output logic [DW-1:0]        data
);
  always_comb begin
    case (dtype_e'(code))
      DT_I, DT_Q, DT_AGC_RT, DT_AGC_SM, DT_RNG_A, DT_RNG_B:
        data = vals[int'(code)*DW +: DW];
      default:
        data = '0;
    endcase
  end
endmodule

// File: rtl/seqrd_chan.sv
module seqrd_chan
  import seqrd_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      new_out,
  input  logic                      rd_hit,
  input  logic [NTYPES*DW-1:0]      vals_in,
  input  logic [SEQ_MAX*SLOT_W-1:0] slots,
  input  logic [SLOT_W-1:0]         last,
  input  logic                      irq_en,
  output logic [DW-1:0]             cur_data,
  output logic                      irq
);
  logic [NTYPES*DW-1:0] lat_q;
  logic [SLOT_W-1:0]    ptr_q;
  logic                 irq_q;

  // named events for the assertions
  logic seq_rewind, seq_step, irq_clr;
  assign seq_rewind = new_out;
  assign seq_step   = rd_hit && !new_out;
  assign irq_clr    = rd_hit && (ptr_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= '0;
      ptr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (seq_rewind) begin
        lat_q <= vals_in;
        ptr_q <= '0;
      end else if (seq_step) begin
        ptr_q <= step_ptr(ptr_q, last);
      end
      if (seq_rewind)   irq_q <= irq_en;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  seqrd_sel #(.DW(DW)) u_sel (
    .code (slot_code(slots, ptr_q)),
    .vals (lat_q),
    .data (cur_data)
  );

  assign irq = irq_q;

  // R6
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rewind |=> (ptr_q == '0));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_step && ptr_q < last) |=> (ptr_q == $past(ptr_q) + 1'b1));
  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_step && ptr_q == last) |=> (ptr_q == '0));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && !new_out) |=> $stable(ptr_q));
  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !new_out |=> $stable(lat_q));
  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_out |=> (irq == $past(irq_en)));
  // R9
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && rd_hit && ptr_q == '0 && !new_out) |=> !irq);
endmodule

// File: rtl/seqrd_port.sv
module seqrd_port
  import seqrd_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int DW        = 16,
  parameter int AW        = 3,
  parameter int BASE_ADDR = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_rd,
  input  logic [AW-1:0]       host_addr,
  input  logic [NCH-1:0]      new_out,
  input  logic [NCH*DW-1:0]   i_val,
  input  logic [NCH*DW-1:0]   q_val,
  input  logic [NCH*DW-1:0]   agc_rt,
  input  logic [NCH*DW-1:0]   agc_smp,
  input  logic [NCH*DW-1:0]   rng_a,
  input  logic [NCH*DW-1:0]   rng_b,
  input  logic [NCH*PROG_W-1:0] seq_prog,
  output logic [DW-1:0]       rd_data,
  output logic [NCH-1:0]      irq
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int RSV_W = IRQ_EN_BIT - (LAST_LSB + SLOT_W);

  logic [NCH-1:0]       hit;
  logic [NCH*DW-1:0]    cur_all;
  logic [NCH*RSV_W-1:0] unused_rsvd;
  logic [IW-1:0]        sel_idx;
  logic                 hit_any;
  logic [DW-1:0]        rd_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PROG_W-1:0] pw;
    assign pw = seq_prog[c*PROG_W +: PROG_W];
    assign hit[c] = host_rd && (host_addr == AW'(BASE_ADDR + c));
    assign unused_rsvd[c*RSV_W +: RSV_W] = pw[IRQ_EN_BIT-1 : LAST_LSB+SLOT_W];

    seqrd_chan #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .new_out  (new_out[c]),
      .rd_hit   (hit[c]),
      .vals_in  ({rng_b[c*DW +: DW], rng_a[c*DW +: DW], agc_smp[c*DW +: DW],
                  agc_rt[c*DW +: DW], q_val[c*DW +: DW], i_val[c*DW +: DW]}),
      .slots    (pw[SEQ_MAX*SLOT_W-1:0]),
      .last     (pw[LAST_LSB +: SLOT_W]),
      .irq_en   (pw[IRQ_EN_BIT]),
      .cur_data (cur_all[c*DW +: DW]),
      .irq      (irq[c])
    );
  end

  assign hit_any = |hit;

  always_comb begin
    sel_idx = '0;
    for (int c = 0; c < NCH; c++)
      if (hit[c]) sel_idx = IW'(c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_q <= '0;
    else if (hit_any) rd_q <= cur_all[int'(sel_idx)*DW +: DW];
  end

  assign rd_data = rd_q;

  // R10
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |=> $stable(rd_data));
  // R3
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: tb/seqrd_port_tb_top.sv
module seqrd_port_tb_top;
  localparam int NCH = 4, DW = 16, AW = 3, BASE = 4;

  logic clk = 1'b0, rst_n = 1'b0, host_rd = 1'b0;
  logic [AW-1:0]     host_addr = '0;
  logic [NCH-1:0]    new_out = '0;
  logic [NCH*DW-1:0] i_val = '0, q_val = '0, agc_rt = '0, agc_smp = '0, rng_a = '0, rng_b = '0;
  logic [NCH*32-1:0] seq_prog = '0;
  logic [DW-1:0]     rd_data;
  logic [NCH-1:0]    irq;

  always #2 clk = ~clk;

  seqrd_port #(.NCH(NCH), .DW(DW), .AW(AW), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_addr(host_addr),
    .new_out(new_out), .i_val(i_val), .q_val(q_val), .agc_rt(agc_rt),
    .agc_smp(agc_smp), .rng_a(rng_a), .rng_b(rng_b), .seq_prog(seq_prog),
    .rd_data(rd_data), .irq(irq));

  int total = 0, bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  logic [DW-1:0] mlat [NCH][6];
  int            mptr [NCH];
  logic [31:0]   mprog[NCH];

  function automatic logic [DW-1:0] val_of(int ch, int t, int gen);
    return {ch[3:0], t[3:0], gen[7:0]};
  endfunction

  function automatic logic [31:0] mk_prog(bit en, int last, int s0, int s1, int s2,
                                          int s3, int s4, int s5, int s6, int s7);
    logic [31:0] p = '0;
    p[2:0] = s0[2:0]; p[5:3] = s1[2:0]; p[8:6] = s2[2:0]; p[11:9] = s3[2:0];
    p[14:12] = s4[2:0]; p[17:15] = s5[2:0]; p[20:18] = s6[2:0]; p[23:21] = s7[2:0];
    p[26:24] = last[2:0]; p[31] = en;
    return p;
  endfunction

  // expected value of the next read on channel ch
  function automatic logic [DW-1:0] model_val(int ch);
    int code = int'(mprog[ch][mptr[ch]*3 +: 3]);
    return (code < 6) ? mlat[ch][code] : '0;
  endfunction

  function automatic int model_next(int ch);
    return (mptr[ch] >= int'(mprog[ch][26:24])) ? 0 : mptr[ch] + 1;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive_vals(int gen);
    for (int c = 0; c < NCH; c++) begin
      i_val[c*DW +: DW]   = val_of(c, 0, gen);
      q_val[c*DW +: DW]   = val_of(c, 1, gen);
      agc_rt[c*DW +: DW]  = val_of(c, 2, gen);
      agc_smp[c*DW +: DW] = val_of(c, 3, gen);
      rng_a[c*DW +: DW]   = val_of(c, 4, gen);
      rng_b[c*DW +: DW]   = val_of(c, 5, gen);
    end
  endtask

  task automatic model_capture(logic [NCH-1:0] mask, int gen);
    for (int c = 0; c < NCH; c++)
      if (mask[c]) begin
        for (int t = 0; t < 6; t++) mlat[c][t] = val_of(c, t, gen);
        mptr[c] = 0;
      end
  endtask

  task automatic pulse_new(logic [NCH-1:0] mask, int gen);
    drive_vals(gen);
    new_out = mask;
    model_capture(mask, gen);
    @(negedge clk);
    new_out = '0;
  endtask

  // driver: push the expected item, then strobe the read for one cycle
  task automatic do_read(int ch, string req);
    exp_q.push_back(model_val(ch));
    tag_q.push_back(req);
    mptr[ch] = model_next(ch);
    host_rd = 1'b1;
    host_addr = AW'(BASE + ch);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // R11: read and new output on the same channel in one cycle
  task automatic read_with_new(int ch, int gen);
    exp_q.push_back(model_val(ch));
    tag_q.push_back("R11");
    drive_vals(gen);
    new_out = '0;
    new_out[ch] = 1'b1;
    model_capture(new_out, gen);
    host_rd = 1'b1;
    host_addr = AW'(BASE + ch);
    @(negedge clk);
    host_rd = 1'b0;
    new_out = '0;
  endtask

  // monitor: compare after each edge that carries a hit read
  always @(posedge clk) begin
    if (rst_n && host_rd && int'(host_addr) >= BASE && int'(host_addr) < BASE + NCH) begin
      #1;
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected read", {16'h0, rd_data}, 32'h0);
      else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, {16'h0, rd_data}, {16'h0, e});
      end
    end
  end

  initial begin
    #(4 * 100000);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    for (int c = 0; c < NCH; c++) begin
      mptr[c] = 0;
      for (int t = 0; t < 6; t++) mlat[c][t] = '0;
    end
    mprog[0] = mk_prog(1'b1, 3, 5, 0, 3, 1, 0, 0, 0, 0);
    mprog[1] = mk_prog(1'b1, 7, 0, 1, 2, 3, 4, 5, 6, 7);
    mprog[2] = mk_prog(1'b0, 2, 2, 6, 4, 0, 0, 0, 0, 0);
    mprog[3] = mk_prog(1'b1, 1, 7, 1, 0, 0, 0, 0, 0, 0);
    for (int c = 0; c < NCH; c++) seq_prog[c*32 +: 32] = mprog[c];

    repeat (3) @(negedge clk);
    // R1: reset state
    check(rd_data === '0, "R1 rd_data", {16'h0, rd_data}, 32'h0);
    check(irq === '0, "R1 irq", {28'h0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq === '0 && rd_data === '0, "R1 after release", {12'h0, irq, rd_data}, 32'h0);

    pulse_new(4'b1111, 1);
    // R8: enables 1,1,0,1 for channels 0..3
    check(irq === 4'b1011, "R8 irq set", {28'h0, irq}, 32'hb);

    do_read(0, "R2 code5");
    // R9: first read clears only channel 0
    check(irq === 4'b1010, "R9 irq clear", {28'h0, irq}, 32'ha);
    do_read(0, "R4 step");
    do_read(0, "R4 step");
    do_read(0, "R5 last slot");
    do_read(0, "R5 wrap");

    drive_vals(2); // no new output: must not be seen
    @(negedge clk);
    do_read(0, "R7 captured");

    for (int k = 0; k < 8; k++) do_read(1, "R2 all codes");
    check(irq[1] === 1'b0, "R9 ch1", {31'h0, irq[1]}, 32'h0);
    do_read(0, "R3 other channel untouched");

    for (int k = 0; k < 3; k++) do_read(2, "R2 zero code");
    check(irq[2] === 1'b0, "R8 disabled", {31'h0, irq[2]}, 32'h0);

    held = rd_data;
    host_rd = 1'b1; host_addr = 3'd1;
    @(negedge clk);
    host_rd = 1'b0;
    check(rd_data === held, "R10 data held", {16'h0, rd_data}, {16'h0, held});
    do_read(0, "R10 pointer held");

    do_read(1, "R4 before rewind");
    pulse_new(4'b0010, 3);
    check(irq[1] === 1'b1, "R8 reraise", {31'h0, irq[1]}, 32'h1);
    do_read(1, "R6 rewind");
    do_read(1, "R6 second slot");

    do_read(3, "R2 code7");
    read_with_new(3, 4);
    check(irq[3] === 1'b1, "R11 irq", {31'h0, irq[3]}, 32'h1);
    do_read(3, "R11 rewound");
    do_read(3, "R11 next");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule